// File: doc/BRIEF.md
# Dual-Lane Serial Result Shifter

This block is the serial readout path of an eight-channel sampling converter. It holds one 14-bit result per channel and shifts them out on two serial data lanes. A host supplies a serial clock and an active-low chip select, and the block samples both of them in a faster system clock domain. When chip select goes low, both lanes and a first-channel indicator leave three-state, and each lane presents the MSB of its current result. Every later serial clock rising edge moves the next bit out. The host captures each bit on the falling edge, and a channel takes 14 clocks.

Lane A starts at channel 1 and lane B starts at channel 5. Both lanes advance through the channels together and wrap around the eight results. A host using both lanes gets all eight results in 56 clocks. A host using one lane gets all eight results in 112 clocks: lane A gives 1 to 8 and lane B gives 5, 6, 7, 8, 1, 2, 3, 4. Chip select may frame the whole read or frame each channel separately, and the sequence carries on across frames. The conversion engine delivers new results by lowering its busy signal, which reloads the held results and rewinds both lanes. Reads at any other time, including while busy is high, return the held results.

Top module: `serial_result_shifter`

## Requirements
- R1: Within four system clocks of a chip-select falling edge `driveEn` is 1. Within four system clocks of a chip-select rising edge `driveEn` is 0, and `doutA`, `doutB` and `firstData` read 0 while `driveEn` is 0.
- R2: The MSB of the current result appears at chip-select fall. Each serial clock rising edge (clock idles high) moves the next lower bit onto the lane, so 14 falling-edge captures yield the result MSB first. If chip select is still low, the rising edge after the 14th falling edge presents the MSB of the next channel.
- R3: With both lanes read over one 56-clock frame, lane A yields channels 1, 2, 3, 4 and lane B yields channels 5, 6, 7, 8.
- R4: Lane A alone yields channels 1 to 8 in order over 112 clocks. Lane B alone yields channels 5, 6, 7, 8, 1, 2, 3, 4.
- R5: Once eight channels have been read since the last reload, both lanes shift out all-zero words.
- R6: `firstData` goes to 1 at a chip-select falling edge when lane A's current channel is channel 1, and it is 0 after that channel's 14th falling edge. It never goes to 1 for any later channel, including when channel 1 appears on lane B.
- R7: When chip select is raised between channels and lowered again, the read continues with the next channel and does not restart.
- R8: A falling edge of `busy` captures `resultsIn` and rewinds both lanes to their start channels. Changes on `resultsIn` at any other time, and reads while `busy` is high, leave the shifted data unchanged. Channel n (1 to 8) sits at `resultsIn[(n-1)*14 +: 14]`.
- R9: After reset `driveEn`, `doutA`, `doutB` and `firstData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Conversion busy; its falling edge delivers new results |
| resultsIn | input | NUM_CH*RES_W | Results from the conversion engine, channel 1 in the low bits |
| sclk | input | 1 | Host serial clock, idles high |
| csN | input | 1 | Host chip select, active low |
| doutA | output | 1 | Lane A serial data |
| doutB | output | 1 | Lane B serial data |
| firstData | output | 1 | High while channel 1 is being read on lane A |
| driveEn | output | 1 | Output enable for the lanes and the indicator (0 means three-state) |

## Verification
The assertions assume the following about the inputs. Every serial clock or chip-select level lasts longer than the synchronizer latency. Chip select changes only while the serial clock is high. `busy` never falls in the same system cycle as a serial pin edge. The stimulus meets these assumptions: it holds each serial clock phase for six system clocks, moves chip select only with the serial clock high, and changes `busy` and `resultsIn` only between channel reads. Under these conditions the shift counter stays below 14, the channel slot never passes eight, and the first-channel flag is only ever high on slot zero.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  // Strobes issued by the control towards the datapath
  typedef struct packed {
    logic loadHold;   // capture new conversion results
    logic loadShift;  // load both lane shift registers from the current slot
    logic shiftOut;   // advance both lane shift registers by one bit
  } shStrobe_t;

endpackage

// File: rtl/sr_edge_sync.sv
module sr_edge_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic level,
  output logic edgeSeen
);

  logic [STAGES-1:0] pipe;
  logic              lastLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe      <= {STAGES{RESET_VAL}};
      lastLevel <= RESET_VAL;
    end else begin
      pipe[0] <= pinIn;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
      lastLevel <= pipe[STAGES-1];
    end
  end

  assign level    = pipe[STAGES-1];
  assign edgeSeen = pipe[STAGES-1] ^ lastLevel;

endmodule

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import shifter_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 14,
  parameter int SLOT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csLvl,
  input  logic              csEdge,
  input  logic              sclkLvl,
  input  logic              sclkEdge,
  input  logic              busyLvl,
  input  logic              busyEdge,
  output shStrobe_t         strobe,
  output logic [SLOT_W-1:0] slot,
  output logic              outEn,
  output logic              firstFlag
);

  localparam int CNT_W = $clog2(RES_W);

  logic [CNT_W-1:0] fallCnt;
  logic csFall, csRise, sclkRise, sclkFall, busyFall, atBoundary;

  assign csFall     = csEdge & ~csLvl;
  assign csRise     = csEdge & csLvl;
  assign sclkRise   = sclkEdge & sclkLvl;
  assign sclkFall   = sclkEdge & ~sclkLvl;
  assign busyFall   = busyEdge & ~busyLvl;
  assign atBoundary = (fallCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot      <= '0;
      fallCnt   <= '0;
      outEn     <= 1'b0;
      firstFlag <= 1'b0;
    end else begin
      if (busyFall) begin
        slot    <= '0;
        fallCnt <= '0;
      end else if (sclkFall && outEn) begin
        if (fallCnt == CNT_W'(RES_W - 1)) begin
          fallCnt   <= '0;
          firstFlag <= 1'b0;
          if (slot != SLOT_W'(NUM_CH)) slot <= slot + SLOT_W'(1);
        end else begin
          fallCnt <= fallCnt + CNT_W'(1);
        end
      end
      if (csFall) begin
        outEn     <= 1'b1;
        firstFlag <= (slot == '0);
      end else if (csRise) begin
        outEn     <= 1'b0;
        firstFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.loadHold  = busyFall;
    strobe.loadShift = atBoundary && (csFall || (sclkRise && outEn));
    strobe.shiftOut  = sclkRise && outEn && !atBoundary;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt < CNT_W'(RES_W)); // R2
  AST_SLOT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    slot <= SLOT_W'(NUM_CH)); // R5
  AST_FLAG_ON_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    firstFlag |-> (slot == '0)); // R6
  AST_SELECT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    csFall |=> outEn); // R1
  AST_BUSY_REWINDS: assert property (@(posedge clk) disable iff (!rstN)
    busyFall |=> (slot == '0 && fallCnt == '0)); // R8

endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import shifter_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 14,
  parameter int SLOT_W = $clog2(NUM_CH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  shStrobe_t               strobe,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [NUM_CH*RES_W-1:0] resultsIn,
  output logic [1:0]              laneBit
);

  localparam int HALF_CH = NUM_CH / 2;
  localparam int IDX_W   = $clog2(NUM_CH);

  logic [NUM_CH-1:0][RES_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (!rstN) holdReg <= '0;
    else if (strobe.loadHold) holdReg <= resultsIn;
  end

  for (genvar gl = 0; gl < 2; gl++) begin : g_lane
    localparam int OFFSET = gl * HALF_CH;
    logic [RES_W-1:0] shReg;
    logic [RES_W-1:0] nextWord;
    logic [IDX_W-1:0] chanIdx;

    always_comb begin
      chanIdx  = IDX_W'((int'(slot) + OFFSET) % NUM_CH);
      nextWord = (slot >= SLOT_W'(NUM_CH)) ? '0 : holdReg[chanIdx];
    end

    always_ff @(posedge clk) begin
      if (!rstN) shReg <= '0;
      else if (strobe.loadShift) shReg <= nextWord;
      else if (strobe.shiftOut) shReg <= {shReg[RES_W-2:0], 1'b0};
    end

    assign laneBit[gl] = shReg[RES_W-1];

    AST_ZERO_PAST_END: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadShift && slot >= SLOT_W'(NUM_CH)) |=> (shReg == '0)); // R5
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadShift, strobe.shiftOut})); // R2

endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter
  import shifter_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int RES_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busy,
  input  logic [NUM_CH*RES_W-1:0] resultsIn,
  input  logic                    sclk,
  input  logic                    csN,
  output logic                    doutA,
  output logic                    doutB,
  output logic                    firstData,
  output logic                    driveEn
);

  localparam int SLOT_W = $clog2(NUM_CH + 1);

  logic csLvl, csEdge, sclkLvl, sclkEdge, busyLvl, busyEdge;
  logic outEn, firstFlag;
  logic [SLOT_W-1:0] slot;
  logic [1:0] laneBit;
  shStrobe_t strobe;

  sr_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_csSync (
    .clk(clk), .rstN(rstN), .pinIn(csN), .level(csLvl), .edgeSeen(csEdge));
  sr_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclkSync (
    .clk(clk), .rstN(rstN), .pinIn(sclk), .level(sclkLvl), .edgeSeen(sclkEdge));
  sr_edge_sync #(.STAGES(1), .RESET_VAL(1'b0)) u_busyEdge (
    .clk(clk), .rstN(rstN), .pinIn(busy), .level(busyLvl), .edgeSeen(busyEdge));

  sr_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csLvl(csLvl), .csEdge(csEdge), .sclkLvl(sclkLvl), .sclkEdge(sclkEdge),
    .busyLvl(busyLvl), .busyEdge(busyEdge),
    .strobe(strobe), .slot(slot), .outEn(outEn), .firstFlag(firstFlag));

  sr_datapath #(.NUM_CH(NUM_CH), .RES_W(RES_W), .SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slot),
    .resultsIn(resultsIn), .laneBit(laneBit));

  assign doutA     = laneBit[0] & outEn;
  assign doutB     = laneBit[1] & outEn;
  assign firstData = firstFlag & outEn;
  assign driveEn   = outEn;

endmodule

// File: tb/sim_serial_result_shifter.sv
module sim_serial_result_shifter;

  localparam int NUM_CH = 8;
  localparam int RES_W  = 14;
  localparam int HALF   = 6;

  logic clk = 1'b0;
  always #2.5ns clk = ~clk;

  logic rstN = 1'b0, busy = 1'b0, sclk = 1'b1, csN = 1'b1;
  logic [NUM_CH*RES_W-1:0] resultsIn = '0;
  logic doutA, doutB, firstData, driveEn;

  serial_result_shifter u0 (
    .clk(clk), .rstN(rstN), .busy(busy), .resultsIn(resultsIn),
    .sclk(sclk), .csN(csN), .doutA(doutA), .doutB(doutB),
    .firstData(firstData), .driveEn(driveEn));

  typedef struct {
    logic [RES_W-1:0] a;
    logic [RES_W-1:0] b;
    logic             fs;
    string            tag;
  } item_t;

  item_t expQ[$];
  item_t gotQ[$];
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [RES_W-1:0] hold [NUM_CH];
  int mslot = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] expWord(input int lane);
    if (mslot >= NUM_CH) return '0;
    return hold[(mslot + lane * (NUM_CH / 2)) % NUM_CH];
  endfunction

  function automatic logic [NUM_CH*RES_W-1:0] pattern(input int seed);
    logic [NUM_CH*RES_W-1:0] v;
    for (int k = 0; k < NUM_CH; k++)
      v[k*RES_W +: RES_W] = RES_W'((seed * 37 + k * 1111) ^ (k << 10) ^ (seed << 12));
    return v;
  endfunction

  task automatic loadResults(input logic [NUM_CH*RES_W-1:0] v);
    @(negedge clk) resultsIn = v; busy = 1'b1;
    repeat (4) @(negedge clk);
    busy = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NUM_CH; k++) hold[k] = v[k*RES_W +: RES_W];
    mslot = 0;
  endtask

  task automatic selectLow(input string tag);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    check(driveEn === 1'b1, {tag, " R1 enable after select"}, int'(driveEn), 1);
  endtask

  task automatic deselect(input string tag);
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
    check(driveEn === 1'b0 && doutA === 1'b0 && doutB === 1'b0 && firstData === 1'b0,
          {tag, " R1 released after deselect"},
          int'({driveEn, doutA, doutB, firstData}), 0);
  endtask

  // driver: pushes the expected item, shifts one channel, pushes what came out
  task automatic readChan(input string tag, input bit viaCsFall);
    item_t e, g;
    e.a = expWord(0); e.b = expWord(1); e.fs = viaCsFall && (mslot == 0); e.tag = tag;
    expQ.push_back(e);
    g.a = '0; g.b = '0; g.fs = 1'b0; g.tag = tag;
    for (int b = 0; b < RES_W; b++) begin
      g.a = {g.a[RES_W-2:0], doutA};
      g.b = {g.b[RES_W-2:0], doutB};
      if (b == 0) g.fs = firstData;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      if (b == RES_W - 1)
        check(firstData === 1'b0, {tag, " R6 flag low after 14th fall"}, int'(firstData), 0);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    gotQ.push_back(g);
    if (mslot < NUM_CH) mslot++;
  endtask

  task automatic readFrame(input int n, input bit perChannel, input string tag);
    @(negedge clk);
    if (!perChannel) selectLow(tag);
    for (int i = 0; i < n; i++) begin
      if (perChannel) selectLow(tag);
      readChan(tag, perChannel || i == 0);
      if (perChannel) deselect(tag);
    end
    if (!perChannel) deselect(tag);
  endtask

  // monitor: compares produced items against expected ones
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        item_t g, e;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        check(g.a === e.a, {e.tag, " lane A word"}, int'(g.a), int'(e.a));
        check(g.b === e.b, {e.tag, " lane B word"}, int'(g.b), int'(e.b));
        check(g.fs === e.fs, {e.tag, " R6 flag at start"}, int'(g.fs), int'(e.fs));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(driveEn === 1'b0 && doutA === 1'b0 && doutB === 1'b0 && firstData === 1'b0,
          "R9 reset outputs", int'({driveEn, doutA, doutB, firstData}), 0);

    // R3 dual-lane read in one frame of 56 clocks
    loadResults(pattern(1));
    readFrame(4, 1'b0, "R2 R3 dual lane");

    // R4 lane A alone, R5 past the end, R8 resultsIn change without busy ignored
    loadResults(pattern(2));
    @(negedge clk) resultsIn = pattern(3);
    readFrame(NUM_CH + 1, 1'b0, "R4 R5 R8 single frame");

    // R7 per-channel framing, lane B order 5..8,1..4, then zeros
    loadResults(pattern(4));
    readFrame(NUM_CH + 1, 1'b1, "R4 R5 R7 per channel");

    // R8 read while busy high returns held data; busy fall reloads and rewinds
    loadResults(pattern(5));
    readFrame(2, 1'b1, "R7 partial");
    @(negedge clk) busy = 1'b1; resultsIn = pattern(6);
    readFrame(1, 1'b1, "R8 during busy");
    @(negedge clk) busy = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NUM_CH; k++) hold[k] = resultsIn[k*RES_W +: RES_W];
    mslot = 0;
    readFrame(1, 1'b1, "R8 after reload");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0 && gotQ.size() == 0, "scoreboard drained",
          expQ.size() + gotQ.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule